// File: doc/BRIEF.md
# Serial Converter Mode Sequencer

This block is the digital control core of a 16-bit successive-approximation converter that a host drives over a full-duplex serial link with chip select, data in and data out. Each transaction begins with a configuration byte. Its first 1 bit, seen while the block is idle, is the start marker, and the two bits after it pick one of four modes. Two modes are plain conversions that differ in acquisition length. One mode calibrates. The last mode converts and then powers down. The host reads a conversion result as two further bytes, most significant bit first.

The sample path is outside the block. When acquisition ends, the block requests the result word on a valid/ready port. A late word stretches the transaction rather than corrupting it. Calibration is a counted interval of `CAL_CYCLES` serial clocks, and it can be interrupted. A hardware shutdown input forces a sleep state from any state. The sleep state is left only by a new start marker.

Top module: `sar_mode_sequencer`

## Requirements
- R1: While idle with `cs_n` low, 0 bits on `sdi` are ignored and `busy` stays low. The first 1 bit is the start marker, and `busy` is high after that clock. The next two clocks deliver the high mode bit and then the low mode bit.
- R2: Mode 00 is a short-acquisition conversion. Acquisition takes 5 clocks after the low mode bit, the transaction takes 24 clocks in total, and `smp_ready` is first high after the 7th clock (counted from the start-marker clock).
- R3: Mode 11 is a long-acquisition conversion. Acquisition takes 13 clocks, the transaction takes 32 clocks, and `smp_ready` is first high after the 15th clock.
- R4: `sdo` changes after a rising edge. It shows result bit 15 in the cycle after the capture edge and the next lower bit after each following clock. It is 0 at all other times. `sdo_oe` is low whenever `cs_n` is high.
- R5: `smp_ready` is high only in the last acquisition clock. The word is taken on the edge where `smp_valid` and `smp_ready` are both high. While `smp_valid` is low, `smp_ready` holds, `sdo` stays 0 and the transaction waits.
- R6: Mode 01 keeps `busy` high for exactly `CAL_CYCLES` clocks after the low mode bit and then returns to idle, whether or not `cs_n` is high.
- R7: A start marker (`cs_n` low, `sdi` high) during calibration ends the calibration, and the block reads a new configuration.
- R8: `shdn_n` low moves the block to sleep (`asleep` high, `busy` low) on the next clock from any state, including calibration. While `shdn_n` is low, start markers are ignored.
- R9: Mode 10 runs a conversion with the acquisition length of the last 00 or 11 command and then sleeps. After reset that length is short (5 clocks).
- R10: In sleep, only a start marker with `shdn_n` high wakes the block. `sdi` high with `cs_n` high does not wake it.
- R11: `cs_n` high during configuration, acquisition or readout abandons the transaction and returns the block to idle.
- R12: After reset the block is idle with `busy`, `asleep` and `smp_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all sampling on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Active-low hardware shutdown |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| smp_valid | input | 1 | Result word offered by the sample path |
| smp_data | input | 16 | Result word |
| smp_ready | output | 1 | Block accepts the result word this cycle |
| busy | output | 1 | Configuration, conversion or calibration in progress |
| asleep | output | 1 | Block is in shutdown |

## Verification
On every cycle, assertions check four things: the forced move to sleep under hardware shutdown, that sleep is left only on a start marker, that `smp_ready` holds while the result word is late, and that the calibration counter stays in range. They also check that the loaded word's top bit appears on `sdo`, that a deasserted select abandons a transaction, and that the stored acquisition length changes only during configuration. The bench scenarios are needed for the rest. Those cover the exact clock counts of both acquisition lengths, the full bit order of the readout and the length of a complete calibration. They also cover mode 10 reusing the previous length, and which stimuli do or do not wake the block from sleep.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CFG   = 3'd1,
    ST_ACQ   = 3'd2,
    ST_SHIFT = 3'd3,
    ST_CAL   = 3'd4,
    ST_SLEEP = 3'd5
  } seq_state_t;

  typedef enum logic [1:0] {
    MODE_SHORT     = 2'b00,
    MODE_CAL       = 2'b01,
    MODE_CONV_DOWN = 2'b10,
    MODE_LONG      = 2'b11
  } seq_mode_t;
endpackage

// File: rtl/sar_seq_cal_timer.sv
module sar_seq_cal_timer #(
  parameter int CAL_CYCLES = 80000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CAL_W = $clog2(CAL_CYCLES + 1);
  localparam logic [CAL_W-1:0] CAL_LAST = CAL_W'(CAL_CYCLES - 1);

  logic [CAL_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (!done)  cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == CAL_LAST);

  p_cal_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAL_LAST);
endmodule

// File: rtl/sar_seq_shifter.sv
module sar_seq_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              active,
  output logic              sdo_bit
);
  logic [DATA_W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sreg <= '0;
    else if (load)    sreg <= data;
    else if (active)  sreg <= {sreg[DATA_W-2:0], 1'b0};
  end

  assign sdo_bit = active ? sreg[DATA_W-1] : 1'b0;

  p_load_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!active || sdo_bit == $past(data[DATA_W-1])));
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int ACQ_SHORT = 5,
  parameter int ACQ_LONG  = 13,
  parameter int DATA_W    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shdn_n,
  input  logic cs_n,
  input  logic sdi,
  input  logic smp_valid,
  input  logic cal_done,
  output logic cal_run,
  output logic shift_en,
  output logic smp_ready,
  output logic busy,
  output logic asleep
);
  localparam int CNT_MAX = (ACQ_LONG > DATA_W) ? ACQ_LONG : DATA_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(ACQ_SHORT - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(ACQ_LONG - 1);
  localparam logic [CNT_W-1:0] SHIFT_LAST = CNT_W'(DATA_W - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             hi_bit;
  logic             acq_long;
  logic             cur_long;
  logic             sleep_after;
  logic             start;
  logic [CNT_W-1:0] acq_last;

  assign start    = !cs_n && sdi;
  assign acq_last = cur_long ? LONG_LAST : SHORT_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      hi_bit      <= 1'b0;
      acq_long    <= 1'b0;
      cur_long    <= 1'b0;
      sleep_after <= 1'b0;
    end else if (!shdn_n) begin
      state <= ST_SLEEP;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_SLEEP: begin
          if (start) begin
            state <= ST_CFG;
            cnt   <= '0;
          end
        end
        ST_CFG: begin
          if (cs_n) begin
            state <= ST_IDLE;
          end else if (cnt == '0) begin
            hi_bit <= sdi;
            cnt    <= CNT_W'(1);
          end else begin
            cnt <= '0;
            unique case (seq_mode_t'({hi_bit, sdi}))
              MODE_SHORT: begin
                acq_long    <= 1'b0;
                cur_long    <= 1'b0;
                sleep_after <= 1'b0;
                state       <= ST_ACQ;
              end
              MODE_LONG: begin
                acq_long    <= 1'b1;
                cur_long    <= 1'b1;
                sleep_after <= 1'b0;
                state       <= ST_ACQ;
              end
              MODE_CONV_DOWN: begin
                cur_long    <= acq_long;
                sleep_after <= 1'b1;
                state       <= ST_ACQ;
              end
              MODE_CAL: state <= ST_CAL;
              default:  state <= ST_IDLE;
            endcase
          end
        end
        ST_ACQ: begin
          if (cs_n) begin
            state <= ST_IDLE;
          end else if (cnt == acq_last) begin
            if (smp_valid) begin
              state <= ST_SHIFT;
              cnt   <= '0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (cs_n) begin
            state <= ST_IDLE;
          end else if (cnt == SHIFT_LAST) begin
            state <= sleep_after ? ST_SLEEP : ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CAL: begin
          if (start) begin
            state <= ST_CFG;
            cnt   <= '0;
          end else if (cal_done) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cal_run   = (state == ST_CAL);
  assign shift_en  = (state == ST_SHIFT);
  assign smp_ready = (state == ST_ACQ) && (cnt == acq_last);
  assign asleep    = (state == ST_SLEEP);
  assign busy      = (state != ST_IDLE) && (state != ST_SLEEP);

  p_shdn_forces_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (state == ST_SLEEP));

  p_sleep_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && !(shdn_n && start)) |=> (state == ST_SLEEP));

  p_ready_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ready && !smp_valid && shdn_n && !cs_n) |=> smp_ready);

  p_acq_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_CFG) |=> $stable(acq_long));

  p_cs_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && shdn_n && (state == ST_CFG || state == ST_ACQ || state == ST_SHIFT))
    |=> (state == ST_IDLE));
endmodule

// File: rtl/sar_mode_sequencer.sv
module sar_mode_sequencer #(
  parameter int DATA_W     = 16,
  parameter int ACQ_SHORT  = 5,
  parameter int ACQ_LONG   = 13,
  parameter int CAL_CYCLES = 80000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shdn_n,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              smp_ready,
  output logic              busy,
  output logic              asleep
);
  logic cal_run, cal_done, shift_en, take;

  sar_seq_ctrl #(
    .ACQ_SHORT(ACQ_SHORT), .ACQ_LONG(ACQ_LONG), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .cs_n(cs_n), .sdi(sdi),
    .smp_valid(smp_valid), .cal_done(cal_done), .cal_run(cal_run),
    .shift_en(shift_en), .smp_ready(smp_ready), .busy(busy), .asleep(asleep)
  );

  sar_seq_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk(clk), .rst_n(rst_n), .run(cal_run), .done(cal_done)
  );

  assign take = smp_valid && smp_ready;

  sar_seq_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(take), .data(smp_data),
    .active(shift_en), .sdo_bit(sdo)
  );

  assign sdo_oe = !cs_n;
endmodule

// File: tb/test_sar_mode_sequencer.sv
`timescale 1ns/1ps
module test_sar_mode_sequencer;
  localparam int CAL = 80000;

  logic clk = 0, rst_n = 0, shdn_n = 1, cs_n = 1, sdi = 0, smp_valid = 0;
  logic [15:0] smp_data = 0;
  logic sdo, sdo_oe, smp_ready, busy, asleep;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sar_mode_sequencer #(.CAL_CYCLES(CAL)) i_sar_mode_sequencer (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .busy(busy), .asleep(asleep));

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic tick(input logic c, input logic d);
    cs_n = c; sdi = d;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run_conv(input logic m1, input logic m0, input int acq,
                          input logic [15:0] val, input bit exp_sleep, input string rq);
    logic [15:0] got;
    got = '0; smp_data = val; smp_valid = 1;
    for (int e = 0; e <= acq + 18; e++) begin
      tick(1'b0, (e == 0) ? 1'b1 : (e == 1) ? m1 : (e == 2) ? m0 : 1'b0);
      if (e == 0) chk(busy == 1, "R1", busy, 1);
      if (e == acq) chk(smp_ready == 0, rq, smp_ready, 0);
      if (e == acq + 1) begin
        chk(smp_ready == 1, rq, smp_ready, 1);
        chk(sdo == 0, "R4", sdo, 0);
      end
      if (e >= acq + 2 && e <= acq + 17) got[15-(e-acq-2)] = sdo;
    end
    chk(got == val, "R4", got, val);
    chk(busy == 0, rq, busy, 0);
    chk(asleep == exp_sleep, "R9", asleep, exp_sleep);
    tick(1'b1, 1'b0);
    chk(sdo_oe == 0, "R4", sdo_oe, 0);
  endtask

  task automatic t_reset;
    chk(busy == 0 && asleep == 0 && smp_ready == 0, "R12", {busy, asleep, smp_ready}, 0);
    chk(sdo_oe == 0, "R12", sdo_oe, 0);
  endtask

  task automatic t_idle_zeros;
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0);
    chk(busy == 0, "R1", busy, 0);
    tick(1'b1, 1'b0);
  endtask

  task automatic t_stall;
    logic [15:0] got;
    smp_data = 16'hC3A5; smp_valid = 0;
    for (int e = 0; e <= 6; e++) tick(1'b0, e == 0);
    chk(smp_ready == 1, "R5", smp_ready, 1);
    for (int i = 0; i < 3; i++) begin
      tick(1'b0, 1'b0);
      chk(smp_ready == 1 && sdo == 0 && busy == 1, "R5", {smp_ready, sdo, busy}, 3'b101);
    end
    smp_valid = 1;
    tick(1'b0, 1'b0);
    got[15] = sdo;
    for (int i = 14; i >= 0; i--) begin
      tick(1'b0, 1'b0);
      got[i] = sdo;
    end
    chk(got == 16'hC3A5, "R5", got, 16'hC3A5);
    tick(1'b0, 1'b0);
    chk(busy == 0, "R5", busy, 0);
    tick(1'b1, 1'b0);
  endtask

  task automatic t_cs_abort;
    tick(1'b0, 1'b1); tick(1'b0, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    chk(busy == 1, "R11", busy, 1);
    tick(1'b1, 1'b0);
    chk(busy == 0 && asleep == 0, "R11", {busy, asleep}, 0);
  endtask

  task automatic send_cal;
    tick(1'b0, 1'b1); tick(1'b0, 1'b0); tick(1'b0, 1'b1);
    cs_n = 1; sdi = 0;
  endtask

  task automatic t_cal_full;
    int n;
    n = 0;
    send_cal();
    while (busy && n < CAL + 10) begin
      @(posedge clk); n++; @(negedge clk);
    end
    chk(n == CAL, "R6", n, CAL);
    chk(asleep == 0, "R6", asleep, 0);
  endtask

  task automatic t_cal_abort_start;
    send_cal();
    for (int i = 0; i < 100; i++) tick(1'b1, 1'b0);
    chk(busy == 1, "R7", busy, 1);
    run_conv(1'b0, 1'b0, 5, 16'h1234, 1'b0, "R7");
  endtask

  task automatic t_cal_abort_shdn;
    send_cal();
    for (int i = 0; i < 20; i++) tick(1'b1, 1'b0);
    shdn_n = 0;
    tick(1'b1, 1'b0);
    chk(asleep == 1 && busy == 0, "R8", {asleep, busy}, 2'b10);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1);
    chk(asleep == 1 && busy == 0, "R8", {asleep, busy}, 2'b10);
    shdn_n = 1;
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b1);
    chk(asleep == 1, "R10", asleep, 1);
    run_conv(1'b0, 1'b0, 5, 16'h0F0F, 1'b0, "R10");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_idle_zeros();
    run_conv(1'b1, 1'b0, 5, 16'hA55A, 1'b1, "R9");
    run_conv(1'b0, 1'b0, 5, 16'h8001, 1'b0, "R2");
    run_conv(1'b1, 1'b1, 13, 16'h7FFE, 1'b0, "R3");
    run_conv(1'b1, 1'b0, 13, 16'h3C96, 1'b1, "R9");
    run_conv(1'b0, 1'b0, 5, 16'hFFFF, 1'b0, "R10");
    t_stall();
    t_cs_abort();
    t_cal_full();
    t_cal_abort_start();
    t_cal_abort_shdn();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule